// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

The block is a watchdog that asks for a system reset when software stops servicing it. Software controls it through one 32-bit control word. When this word is written with its command bit set, a countdown starts and advances by one on each cycle where the slow tick enable is high. If the countdown reaches zero, the block raises a one-cycle reset request and stops.

Once the stored word has its command bit set, the watchdog is guarded by a rolling key. A new write is accepted only if its 7-bit key is the bitwise inverse of the key held in the stored word. Any other write is dropped without effect. A service write therefore alternates between a key and its complement.

Each accepted write reloads the counter from the count field of the word that was stored before the write, not from the new word. A stored count of zero means 256 ticks. A status output shows the current count.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the status reads zero and the reset request is low. The stored control word is cleared, so the first write after reset is accepted whatever its key.
- R2: In the control word, bit 8 is the command bit, bits [15:9] hold the 7-bit key, and bits [8:0] hold the count field. The count field includes the command bit.
- R3: While the stored word has bit 8 set, a write whose key is not the bitwise inverse of the stored key is ignored. The count, the run state and the stored word all stay unchanged.
- R4: While the stored word has bit 8 clear, every write is accepted, whatever its key.
- R5: An accepted write loads the counter from the count field of the previously stored word. A field of zero loads 256.
- R6: An accepted write with bit 8 set starts the countdown. With bit 8 clear it stops the countdown, and the count then holds.
- R7: While the countdown runs, the count drops by one on each cycle where tick is high. It does not change on cycles where tick is low.
- R8: When the count reaches zero, reset_req is high for exactly one cycle. The counter then stays at zero and stopped until the next accepted write.
- R9: status carries the count in bits [8:0], and its upper bits are zero.
- R10: If an accepted write and a tick arrive in the same cycle, the write wins and the count takes the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| tick | input | 1 | Slow tick enable |
| reset_req | output | 1 | One-cycle system reset request |
| status | output | 32 | Current count, zero-extended |

## Verification
The vector walk sends writes that alternate between correct and wrong keys, with the watchdog both enabled and disabled. This separates the key gate from the open-write path. The count fields differ from one write to the next: zero, values with bit 8 set, and small values. A design that reloads from the new word instead of the previous word therefore gives a different status value. Directed cases cover the following:
- the tick that reaches zero, with checks on the width of the pulse and on the counter staying stopped afterwards;
- a wrong key sent after expiry;
- a write and a tick in the same cycle;
- idle cycles with tick low;
- a reset in the middle of a countdown, which reopens the key gate.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    WD_IDLE = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg #(
  parameter int CNT_W   = 9,
  parameter int KEY_W   = 7,
  parameter int CMD_BIT = 8,
  parameter int KEY_LSB = 9,
  localparam int FIELD_W = KEY_LSB + KEY_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  output logic               accept,
  output logic [CNT_W-1:0]   load_field,
  output logic               start_cmd
);
  logic [FIELD_W-1:0] word_q;
  logic               held_en;
  logic [KEY_W-1:0]   held_key;
  logic [KEY_W-1:0]   new_key;

  // The gate is open while the stored word is disabled. Otherwise the new key must be the inverse of the stored key.
  function automatic logic key_passes(input logic en,
                                      input logic [KEY_W-1:0] old_k,
                                      input logic [KEY_W-1:0] new_k);
    return !en || (new_k == ~old_k);
  endfunction

  assign held_en    = word_q[CMD_BIT];
  assign held_key   = word_q[KEY_LSB +: KEY_W];
  assign new_key    = wr_data[KEY_LSB +: KEY_W];
  assign accept     = wr_en && key_passes(held_en, held_key, new_key);
  assign load_field = word_q[CNT_W-1:0];
  assign start_cmd  = wr_data[CMD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (accept) word_q <= wr_data;
  end

  // R3: a write carrying a key that is not the stored key's inverse leaves the word untouched.
  p_bad_key_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && held_en && (new_key != ~held_key)) |=> $stable(word_q));

  // R4: with the stored word disabled, the written data is stored as-is.
  p_open_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !held_en) |=> (word_q == $past(wr_data)));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
  import wdg_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_field,
  input  logic             start,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] EMPTY_RELOAD = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] ONE          = CNT_W'(1);

  wd_state_e state_q;
  logic      dec_evt;
  logic      hit_zero;

  function automatic logic [CNT_W-1:0] reload_of(input logic [CNT_W-1:0] f);
    return (f == '0) ? EMPTY_RELOAD : f;
  endfunction

  assign running  = (state_q == WD_RUN);
  assign dec_evt  = running && tick && !load;
  assign hit_zero = dec_evt && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      state_q <= WD_IDLE;
      expire  <= 1'b0;
    end else begin
      expire <= hit_zero;
      if (load) begin
        count   <= reload_of(load_field);
        state_q <= start ? WD_RUN : WD_IDLE;
      end else if (dec_evt) begin
        count <= count - ONE;
        if (hit_zero) state_q <= WD_IDLE;
      end
    end
  end

  // R7: each tick while running takes exactly one off the count.
  p_step_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !load) |=> (count == $past(count) - ONE));

  // R7: without a load, and without a tick on a running counter, the count holds.
  p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(running && tick)) |=> $stable(count));

  // R5: a nonzero field loads unchanged, and a zero field loads 256.
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_field != '0)) |=> (count == $past(load_field)));
  p_reload_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_field == '0)) |=> (count == EMPTY_RELOAD));

  // R8: the request lasts a single cycle and coincides with a stopped, zero count.
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  p_pulse_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ((count == '0) && !running));

  // R6: the run state after a load follows the command bit.
  p_start_follows_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (running == $past(start)));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 9,
  parameter int KEY_W   = 7,
  parameter int CMD_BIT = 8,
  parameter int KEY_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic              reset_req,
  output logic [DATA_W-1:0] status
);
  localparam int FIELD_W = KEY_LSB + KEY_W;

  logic             accept;
  logic [CNT_W-1:0] load_field;
  logic             start_cmd;
  logic [CNT_W-1:0] count;
  logic             running;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:FIELD_W];

  wdg_ctrl_reg #(
    .CNT_W(CNT_W), .KEY_W(KEY_W), .CMD_BIT(CMD_BIT), .KEY_LSB(KEY_LSB)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data[FIELD_W-1:0]),
    .accept(accept), .load_field(load_field), .start_cmd(start_cmd)
  );

  wdg_countdown #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_field(load_field),
    .start(start_cmd), .tick(tick), .count(count), .running(running),
    .expire(reset_req)
  );

  assign status = {{(DATA_W-CNT_W){1'b0}}, count};

  // R10: a write that is accepted in the same cycle as a tick still starts from the reload value.
  p_write_beats_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tick && (load_field != '0)) |=> (status[CNT_W-1:0] == $past(load_field)));

  // R8: once expired, the counter stays at zero until something is accepted.
  p_stay_expired_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && (count == '0) && !accept) |=> (count == '0));
endmodule

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        reset_req;
  logic [31:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  keyed_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .tick(tick), .reset_req(reset_req), .status(status)
  );

  // Vectors: the word to write, the ticks that follow it, and the status expected afterwards.
  localparam int NV = 7;
  localparam logic [31:0] V_DATA [NV] = '{32'h0000_0005, 32'h0000_5503, 32'h0000_5503,
                                          32'h0000_AB10, 32'h0000_5400, 32'h0000_FF01,
                                          32'h0000_0100};
  localparam int V_TICKS [NV] = '{3, 2, 1, 9, 4, 6, 0};
  localparam int V_EXP   [NV] = '{256, 3, 2, 250, 272, 250, 257};
  localparam string V_TAG [NV] = '{"R4 R5 R6", "R4 R5 R7", "R3",
                                   "R2 R5 R7", "R5 R6", "R4 R5 R7", "R2 R5"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic with_tick);
    wr_en = 1'b1; wr_data = d; tick = with_tick;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 status", status, 32'd0);
    check("R1 reset_req", {31'd0, reset_req}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      do_write(V_DATA[v], 1'b0);
      do_ticks(V_TICKS[v]);
      check({V_TAG[v], " R9 status"}, status, V_EXP[v]);
      check({V_TAG[v], " reset_req"}, {31'd0, reset_req}, 32'd0);
    end

    // R1: a reset in the middle of a countdown clears everything.
    do_reset();
    check("R1 mid-run status", status, 32'd0);
    do_write(32'h0000_0002, 1'b0);
    do_write(32'h0000_0100, 1'b0);
    check("R5 short load", status, 32'd2);
    do_ticks(1);
    check("R8 no early pulse", {31'd0, reset_req}, 32'd0);
    do_ticks(1);
    check("R8 pulse", {31'd0, reset_req}, 32'd1);
    check("R8 count zero", status, 32'd0);
    @(negedge clk);
    check("R8 pulse width", {31'd0, reset_req}, 32'd0);
    do_ticks(3);
    check("R8 stays stopped", status, 32'd0);
    check("R8 no second pulse", {31'd0, reset_req}, 32'd0);

    // R3: after expiry the stored word is still enabled, so a wrong key is dropped.
    do_write(32'h0000_0100, 1'b0);
    check("R3 after expiry", status, 32'd0);
    do_write(32'h0000_FF05, 1'b0);
    check("R5 R6 restart", status, 32'd256);
    do_ticks(2);
    check("R7 run", status, 32'd254);
    do_write(32'h0000_0107, 1'b1);
    check("R10 write over tick", status, 32'd261);
    repeat (5) @(negedge clk);
    check("R7 tick low holds", status, 32'd261);

    // R1: after a reset the key gate is open again.
    do_reset();
    do_write(32'h0000_AB03, 1'b0);
    check("R1 R4 reopened", status, 32'd256);
    do_ticks(1);
    check("R6 running after reopen", status, 32'd255);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule